// File: doc/BRIEF.md
# Flow Statistics Cache with Eviction Merge

This block keeps a per-flow statistic of packet length, either a decaying average or a running byte count, without ever holding up the packet stream. Each cycle at most one packet arrives, carrying a flow key and a length. The key is folded into an index for a small direct-mapped table. A hit updates the resident statistic in place. A miss does not fetch anything. The entry that sits in that slot is pushed out, and the new flow starts over from a fixed start value.

Each entry also carries a decay product. It starts at one and is multiplied by the per-packet decay factor on every packet the entry absorbs. When an entry is pushed out, it goes through a small eviction queue. The queue is drained one entry per cycle into a merge stage. That stage corrects the evicted value as if the flow had started from its older value in the backing array, and then writes the result back. The correction needs only the decay product, not the packet history.

A lookup port returns the merged backing value for any key. It answers only when no eviction is waiting, so a returned value includes every earlier eviction. The decay shift `cfg_k` and the mode `cfg_cnt` are held constant between resets.

Top module: `flowstat_cache`

## Requirements
- R1: After reset every table slot and every backing entry is empty, the eviction queue is empty, and `out_valid` and `rd_ack` are 0.
- R2: The slot index for a key sets index bit i to the XOR of all key bits j with j mod IDX_W = i. With the defaults, bit 0 = k0^k2^k4 and bit 1 = k1^k3^k5. A hit is reported when that slot is occupied by the same key.
- R3: Values are unsigned Q16.16. L is the packet length shifted left by 16. In average mode (`cfg_cnt`=0), a hit on value S gives S - (S>>k) + (L>>k), where k = `cfg_k`. The result appears on `out_val` with `out_hit`=1 in the cycle after the packet.
- R4: A packet is never stalled: every `in_valid` cycle gives `out_valid`=1 in the next cycle. On a miss, `out_hit`=0 and the same update rule is applied to the start value V0. V0 is INIT_VAL (default 64.0) in average mode and 0 in count mode.
- R5: In count mode (`cfg_cnt`=1), the update is S + L modulo 2^32.
- R6: Each slot's decay product is set to 1.0 (0x10000) on install. On every packet the slot absorbs, including the first, the product P becomes P - (P>>k).
- R7: In average mode, an evicted value C with product P and backing value B becomes C - ((P*(V0-B))>>16) when V0 >= B, floored at 0. Otherwise it becomes C + ((P*(B-V0))>>16), saturated at 2^32-1. A key with no backing entry uses B = V0.
- R8: In count mode, the merge is C + B modulo 2^32, with B = 0 for a key with no backing entry.
- R9: A miss on an empty slot evicts nothing. Every eviction of an occupied slot is merged into the backing array exactly once, one per cycle.
- R10: A read (`rd_en` with `rd_key`) is answered with a one-cycle `rd_ack` on the clock edge after the first edge at which the eviction queue is empty. `rd_found` tells whether the key has a backing entry, and `rd_val` is that entry's value, or 0 if there is none.
- R11: A `rd_en` that arrives while an earlier read is still waiting is ignored.
- R12: The eviction queue never overflows; a non-empty queue loses one entry on every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cnt | input | 1 | 1 = byte count, 0 = decaying average |
| cfg_k | input | 4 | Decay shift k, weight 2^-k |
| in_valid | input | 1 | Packet present |
| in_key | input | KEY_W | Flow key |
| in_len | input | LEN_W | Packet length in bytes |
| out_valid | output | 1 | Updated statistic present |
| out_hit | output | 1 | Packet hit a resident flow |
| out_val | output | 32 | Statistic after the update, Q16.16 |
| rd_en | input | 1 | Backing lookup request |
| rd_key | input | KEY_W | Key to look up |
| rd_ack | output | 1 | Lookup answer present |
| rd_found | output | 1 | Key has a backing entry |
| rd_val | output | 32 | Merged backing value |

## Verification
The hardest case to reach is a read that arrives while evictions are still in flight. In that case the answer must wait, and it must include a merge whose backing entry was itself written by an earlier merge. The stimulus alternates two keys that fold to the same slot, so every packet evicts, and it raises reads in the middle of that burst and while one is already waiting. A long random phase over all 64 keys then fills the backing array with multiply-merged flows, and a final sweep reads every key back in both modes.

// File: rtl/flowstat_cache.sv
module flowstat_cache #(
  parameter int KEY_W = 6,
  parameter int IDX_W = 2,
  parameter int LEN_W = 16,
  parameter int QDEPTH = 4,
  parameter logic [31:0] INIT_VAL = 32'h0040_0000
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_cnt,
  input  logic [3:0]       cfg_k,
  input  logic             in_valid,
  input  logic [KEY_W-1:0] in_key,
  input  logic [LEN_W-1:0] in_len,
  output logic             out_valid,
  output logic             out_hit,
  output logic [31:0]      out_val,
  input  logic             rd_en,
  input  logic [KEY_W-1:0] rd_key,
  output logic             rd_ack,
  output logic             rd_found,
  output logic [31:0]      rd_val
);
  localparam int SETS = 1 << IDX_W;
  localparam int KEYS = 1 << KEY_W;
  localparam int QW = $clog2(QDEPTH);
  localparam logic [16:0] ONE = 17'h10000;

  function automatic logic [IDX_W-1:0] fold(input logic [KEY_W-1:0] k);
    logic [IDX_W-1:0] h;
    h = '0;
    for (int i = 0; i < KEY_W; i++) h[i % IDX_W] = h[i % IDX_W] ^ k[i];
    return h;
  endfunction

  logic             c_vld [SETS];
  logic [KEY_W-1:0] c_key [SETS];
  logic [31:0]      c_val [SETS];
  logic [16:0]      c_prd [SETS];
  logic             b_vld [KEYS];
  logic [31:0]      b_val [KEYS];

  logic [KEY_W-1:0] q_key [QDEPTH];
  logic [31:0]      q_val [QDEPTH];
  logic [16:0]      q_prd [QDEPTH];
  logic [QW-1:0]    q_wp, q_rp;
  logic [QW:0]      q_cnt;

  logic             rd_pend;
  logic [KEY_W-1:0] rd_pkey;

  wire [IDX_W-1:0] idx = fold(in_key);
  wire        hit   = c_vld[idx] && (c_key[idx] == in_key);
  wire [31:0] v0    = cfg_cnt ? 32'd0 : INIT_VAL;
  wire [31:0] base  = hit ? c_val[idx] : v0;
  wire [16:0] pbase = hit ? c_prd[idx] : ONE;
  wire [31:0] lenfx = {16'(in_len), 16'h0};
  wire [31:0] upd   = cfg_cnt ? base + lenfx
                              : base - (base >> cfg_k) + (lenfx >> cfg_k);
  wire [16:0] pnew  = pbase - (pbase >> cfg_k);
  wire        evict = in_valid && !hit && c_vld[idx];

  wire             pop  = (q_cnt != '0);
  wire [KEY_W-1:0] hk   = q_key[q_rp];
  wire [31:0]      hv   = q_val[q_rp];
  wire [31:0]      bv   = b_vld[hk] ? b_val[hk] : v0;
  wire             down = (v0 >= bv);
  wire [31:0]      dif  = down ? v0 - bv : bv - v0;
  wire [48:0]      prod = 49'(q_prd[q_rp]) * 49'(dif);
  wire [32:0]      corr = prod[48:16];
  wire [33:0]      sum  = 34'(hv) + 34'(corr);
  logic [31:0]     mrg;

  always_comb begin
    if (cfg_cnt)               mrg = hv + bv;
    else if (down)             mrg = (corr > 33'(hv)) ? 32'd0 : hv - corr[31:0];
    else if (sum[33:32] != 0)  mrg = 32'hFFFF_FFFF;
    else                       mrg = sum[31:0];
  end

  wire             serve = (rd_pend || rd_en) && (q_cnt == '0);
  wire [KEY_W-1:0] skey  = rd_pend ? rd_pkey : rd_key;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SETS; i++) c_vld[i] <= 1'b0;
      for (int i = 0; i < KEYS; i++) b_vld[i] <= 1'b0;
      q_wp <= '0; q_rp <= '0; q_cnt <= '0;
      rd_pend <= 1'b0; rd_pkey <= '0;
      out_valid <= 1'b0; out_hit <= 1'b0; out_val <= '0;
      rd_ack <= 1'b0; rd_found <= 1'b0; rd_val <= '0;
    end else begin
      out_valid <= in_valid;
      out_hit   <= in_valid && hit;
      if (in_valid) begin
        out_val    <= upd;
        c_vld[idx] <= 1'b1;
        c_key[idx] <= in_key;
        c_val[idx] <= upd;
        c_prd[idx] <= pnew;
      end
      if (evict) begin
        q_key[q_wp] <= c_key[idx];
        q_val[q_wp] <= c_val[idx];
        q_prd[q_wp] <= c_prd[idx];
        q_wp <= q_wp + 1'b1;
      end
      if (pop) begin
        b_vld[hk] <= 1'b1;
        b_val[hk] <= mrg;
        q_rp <= q_rp + 1'b1;
      end
      q_cnt <= q_cnt + (QW+1)'(evict) - (QW+1)'(pop);
      rd_ack <= serve;
      if (serve) begin
        rd_found <= b_vld[skey];
        rd_val   <= b_vld[skey] ? b_val[skey] : 32'd0;
        rd_pend  <= 1'b0;
      end else if (rd_en && !rd_pend) begin
        rd_pend <= 1'b1;
        rd_pkey <= rd_key;
      end
    end
  end
endmodule

// File: rtl/flowstat_cache_chk.sv
module flowstat_cache_chk #(
  parameter int CW = 3,
  parameter int QDEPTH = 4
)(
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          out_valid,
  input logic          rd_ack,
  input logic          evict,
  input logic [CW-1:0] q_cnt
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !rd_ack));

  a_r4_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r10_ack_after_empty: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ack |-> ($past(q_cnt) == '0));

  a_r12_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    q_cnt <= CW'(QDEPTH));

  a_r12_drains: assert property (@(posedge clk) disable iff (!rst_n)
    (q_cnt != '0 && !evict) |=> (q_cnt == $past(q_cnt) - 1'b1));
endmodule

bind flowstat_cache flowstat_cache_chk #(.CW(QW+1), .QDEPTH(QDEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
  .rd_ack(rd_ack), .evict(evict), .q_cnt(q_cnt)
);

// File: tb/sim_flowstat_cache.sv
module sim_flowstat_cache;
  logic clk = 0, rst_n = 0, cfg_cnt = 0, in_valid = 0, rd_en = 0;
  logic [3:0] cfg_k = 4'd3;
  logic [5:0] in_key = 0, rd_key = 0;
  logic [15:0] in_len = 0;
  logic out_valid, out_hit, rd_ack, rd_found;
  logic [31:0] out_val, rd_val;
  int errors = 0, checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  flowstat_cache u0 (.clk, .rst_n, .cfg_cnt, .cfg_k, .in_valid, .in_key, .in_len,
    .out_valid, .out_hit, .out_val, .rd_en, .rd_key, .rd_ack, .rd_found, .rd_val);

  localparam longint V0E = 64 * 65536;
  localparam longint M32 = 64'hFFFF_FFFF;

  // reference state
  bit m_vld[4]; int m_key[4]; longint m_val[4], m_prd[4];
  bit b_vld[64]; longint b_val[64];
  int qk[$]; longint qv[$], qp[$];
  bit pend; int pkey;
  bit e_ov, e_hit, e_ack, e_found; longint e_val, e_rv;

  function automatic int mfold(int k);   // R2
    return ((k ^ (k >> 2) ^ (k >> 4)) & 3);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_vld[i]) m_vld[i] = 0;
      foreach (b_vld[i]) b_vld[i] = 0;
      qk.delete(); qv.delete(); qp.delete();
      pend = 0; e_ov = 0; e_ack = 0;
    end else begin
      longint v0, b, nv;
      int ix, kk;
      bit h, was_empty;
      v0 = cfg_cnt ? 0 : V0E;
      was_empty = (qk.size() == 0);
      // read
      e_ack = 0;
      if ((pend || rd_en) && was_empty) begin
        kk = pend ? pkey : int'(rd_key);
        e_ack = 1; e_found = b_vld[kk]; e_rv = b_vld[kk] ? b_val[kk] : 0;
        pend = 0;
      end else if (rd_en && !pend) begin
        pend = 1; pkey = rd_key;
      end
      // drain
      if (!was_empty) begin
        int hk; longint c, p, bb, m, d;
        hk = qk.pop_front(); c = qv.pop_front(); p = qp.pop_front();
        bb = b_vld[hk] ? b_val[hk] : v0;
        if (cfg_cnt) m = (c + bb) & M32;
        else if (v0 >= bb) begin d = (p * (v0 - bb)) >> 16; m = (d > c) ? 0 : c - d; end
        else begin d = (p * (bb - v0)) >> 16; m = c + d; if (m > M32) m = M32; end
        b_vld[hk] = 1; b_val[hk] = m;
      end
      // packet
      e_ov = in_valid;
      if (in_valid) begin
        ix = mfold(in_key);
        h = m_vld[ix] && m_key[ix] == int'(in_key);
        if (!h && m_vld[ix]) begin qk.push_back(m_key[ix]); qv.push_back(m_val[ix]); qp.push_back(m_prd[ix]); end
        b = h ? m_val[ix] : v0;
        if (cfg_cnt) nv = (b + (longint'(in_len) << 16)) & M32;
        else nv = b - (b >> cfg_k) + ((longint'(in_len) << 16) >> cfg_k);
        m_prd[ix] = h ? m_prd[ix] - (m_prd[ix] >> cfg_k) : 65536 - (65536 >> cfg_k);
        m_vld[ix] = 1; m_key[ix] = in_key; m_val[ix] = nv;
        e_hit = h; e_val = nv;
      end
    end
  end

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk(out_valid == e_ov, "R1 R4 out_valid", out_valid, e_ov);
    chk(rd_ack == e_ack, "R1 R10 R11 R12 rd_ack", rd_ack, e_ack);
    if (e_ov && out_valid) begin
      chk(out_hit == e_hit, "R2 R9 out_hit", out_hit, e_hit);
      chk(out_val == e_val[31:0], e_hit ? (cfg_cnt ? "R5 value" : "R3 value") : "R4 value",
          out_val, e_val);
    end
    if (e_ack && rd_ack) begin
      chk(rd_found == e_found, "R9 R10 rd_found", rd_found, e_found);
      chk(rd_val == e_rv[31:0], cfg_cnt ? "R8 R9 merged count" : "R6 R7 R9 merged average",
          rd_val, e_rv);
    end
  end

  task automatic pkt(int k, int len, bit rd = 0, int rk = 0);
    @(negedge clk);
    in_valid = 1; in_key = 6'(k); in_len = 16'(len);
    rd_en = rd; rd_key = 6'(rk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); in_valid = 0; rd_en = 0;
    end
  endtask

  task automatic run_mode(bit cnt, int k);
    @(negedge clk); rst_n = 0; cfg_cnt = cnt; cfg_k = 4'(k); in_valid = 0; rd_en = 0;
    idle(2);
    @(negedge clk); rst_n = 1;
    for (int i = 0; i < 6; i++) pkt(1, 100 + 50 * i);            // R3/R5 hits
    for (int i = 0; i < 8; i++) pkt((i % 2) ? 5 : 0, 1500 - 100 * i, i == 2, 5); // colliding keys, R9
    pkt(0, 64, 1, 0);                                             // R11: ignored while pending
    pkt(5, 40);
    idle(3);
    for (int i = 0; i < 400; i++)
      pkt($urandom_range(63), $urandom_range(1500, 40), ($urandom_range(9) == 0), $urandom_range(63));
    idle(4);
    for (int i = 0; i < 64; i++) begin
      @(negedge clk); in_valid = 0; rd_en = 1; rd_key = 6'(i);
      idle(2);
    end
  endtask

  initial begin
    run_mode(0, 3);
    run_mode(1, 3);
    run_mode(0, 1);
    idle(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule